// File: doc/BRIEF.md
# Two-Channel Serial Storage Adapter Control Registers

This block is the control and status register file of a two-channel serial storage host adapter. A host reaches it over a simple synchronous register bus that is byte addressed: one address, a write strobe, a 32-bit write data word and a combinational 32-bit read data word. Byte-wide registers take their value from the low byte of the write data. They return it zero-extended in the read data.

Each channel keeps a bus-master command byte, a DMA status byte, a six-bit software scratch byte, a twelve-bit link control field, a masked interrupt-enable field and a configuration/status word. The DMA engine on the far side reports activity, error and completion through per-channel flag inputs. The attached device reports its interrupt level and its presence. The block merges both channels' interrupts into one output. It issues a one-cycle link reset pulse when software writes the link control field with bit 0 set. Two summary words give software a one-read view of both channels' DMA and interrupt state.

Top module: `dual_link_csr`

## Requirements
- R1: After reset both configuration/status words (0xA0, 0xE0) read 0x6515_0000, every other register reads zero, and `irq_out` and `link_rst` are low.
- R2: The command byte of channel c reads at 0x00 + 8c and keeps all 8 written bits; writes at 0x00 + 8c and 0x10 + 8c both update it.
- R3: The software byte of channel c reads at 0x01 + 8c and keeps only wdata[5:0]; writes at 0x01 + 8c and 0x11 + 8c both update it.
- R4: A write to the status byte of channel c (0x02 + 8c or 0x12 + 8c) loads bits 6:5 from wdata, clears bit 1 and bit 2 where the written bit is 1 and holds them where it is 0, and leaves bit 0 unchanged; bits 7, 4 and 3 always read 0.
- R5: Status bit 0 follows `dma_active[c]` one cycle later; a pulse on `dma_err_set[c]` sets bit 1 and a pulse on `dma_int_set[c]` sets bit 2, and a set in the same cycle as a clearing write wins.
- R6: The link control field of channel c (0x100 + 0x80c) keeps wdata[11:0]; a write there with wdata[0] = 1 drives `link_rst[c]` high for exactly the next cycle, and a write with wdata[0] = 0 drives no pulse.
- R7: The interrupt-enable field of channel c (0x148 + 0x80c) stores wdata[31:16] ANDed with 0x3EED and reads it back in bits 31:16 with bits 15:0 zero.
- R8: Bit 11 of the configuration/status word of channel c (0xA0 + 0x40c) equals `dev_irq[c]` of the previous cycle; bits 31:16 stay 0x6515.
- R9: `irq_out` is high exactly when bit 11 of either channel's configuration/status word is high.
- R10: The read at 0x10 returns channel 0's command byte in bits 7:0 with bit 4 ORed with channel 0's interrupt bit, bit 6 ORed with channel 1's interrupt bit, bit 14 equal to channel 1's status bit 2, channel 0's status in bits 23:16 and channel 1's status in bits 31:24.
- R11: The read at 0x18 returns channel 1's command byte in bits 7:0 with bit 4 ORed with channel 1's interrupt bit and channel 1's status in bits 23:16.
- R12: The link status word of channel c (0x104 + 0x80c) reads 0x113 while `dev_present[c]` is high and zero otherwise.
- R13: Every address not listed above reads zero, and writes there or to read-only words change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dev_irq | input | 2 | Per-channel device interrupt level |
| dev_present | input | 2 | Per-channel device presence |
| dma_active | input | 2 | Per-channel DMA engine busy level |
| dma_err_set | input | 2 | Per-channel DMA error flag set pulse |
| dma_int_set | input | 2 | Per-channel DMA completion flag set pulse |
| irq_out | output | 1 | Combined interrupt request |
| link_rst | output | 2 | Per-channel one-cycle link reset pulse |

## Verification
On every cycle the assertions check that the combined interrupt tracks the previous cycle's device interrupt levels, that a link reset pulse always has a qualifying link control write behind it, that a clearing status write drops the completion flag unless a set arrives with it, and that the constant fields of the interrupt-enable, configuration and unmapped reads hold. The field masks, the alias offsets, the exact packing of both summary words, the set-over-clear priority and the complete absence of effect of writes to unmapped addresses need the bench's sweeps over every written byte value and every address.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int NCH          = 2;
  localparam int BYTE_W       = 8;
  localparam int SWD_W        = 6;
  localparam int LCTL_W       = 12;
  localparam int IEN_W        = 16;
  localparam int IRQ_BIT      = 11;

  localparam int CH_STRIDE    = 8;      // byte registers per channel
  localparam int ALIAS_BASE   = 'h10;   // write aliases, summary reads
  localparam int CFG_BASE     = 'hA0;
  localparam int CFG_STRIDE   = 'h40;
  localparam int LINK_BASE    = 'h100;
  localparam int LINK_STRIDE  = 'h80;
  localparam int LSTS_OFF     = 'h4;
  localparam int IEN_OFF      = 'h48;

  localparam logic [IEN_W-1:0] IEN_MASK   = 16'h3EED;
  localparam logic [15:0]      CFG_HI     = 16'h6515;
  localparam logic [15:0]      LSTS_UP    = 16'h0113;

  typedef struct packed {
    logic [BYTE_W-1:0] cmd;
    logic [SWD_W-1:0]  swd;
    logic [BYTE_W-1:0] sts;
    logic [LCTL_W-1:0] lctl;
    logic [IEN_W-1:0]  ien;
    logic              irq;
  } chan_view_t;
endpackage

// File: rtl/dlc_chan.sv
module dlc_chan #(
  parameter int CH     = 0,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                irq_in,
  input  logic                dma_active,
  input  logic                dma_err_set,
  input  logic                dma_int_set,
  output dlc_pkg::chan_view_t view,
  output logic                link_rst
);
  import dlc_pkg::*;

  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(CH * CH_STRIDE);
  localparam logic [ADDR_W-1:0] A_SWD   = ADDR_W'(CH * CH_STRIDE + 1);
  localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(CH * CH_STRIDE + 2);
  localparam logic [ADDR_W-1:0] A_CMD_A = ADDR_W'(ALIAS_BASE + CH * CH_STRIDE);
  localparam logic [ADDR_W-1:0] A_SWD_A = ADDR_W'(ALIAS_BASE + CH * CH_STRIDE + 1);
  localparam logic [ADDR_W-1:0] A_STS_A = ADDR_W'(ALIAS_BASE + CH * CH_STRIDE + 2);
  localparam logic [ADDR_W-1:0] A_LCTL  = ADDR_W'(LINK_BASE + CH * LINK_STRIDE);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(LINK_BASE + CH * LINK_STRIDE + IEN_OFF);

  logic hit_cmd, hit_swd, hit_sts, hit_lctl, hit_ien;

  logic [BYTE_W-1:0] cmd_q, cmd_n;
  logic [SWD_W-1:0]  swd_q, swd_n;
  logic [BYTE_W-1:0] sts_q, sts_n;
  logic [LCTL_W-1:0] lctl_q, lctl_n;
  logic [IEN_W-1:0]  ien_q, ien_n;
  logic              irq_q, lrst_q, lrst_n;

  always_comb begin
    hit_cmd  = wr && (addr == A_CMD || addr == A_CMD_A);
    hit_swd  = wr && (addr == A_SWD || addr == A_SWD_A);
    hit_sts  = wr && (addr == A_STS || addr == A_STS_A);
    hit_lctl = wr && (addr == A_LCTL);
    hit_ien  = wr && (addr == A_IEN);
  end

  always_comb begin
    cmd_n  = wdata[BYTE_W-1:0];
    swd_n  = wdata[SWD_W-1:0];
    lctl_n = wdata[LCTL_W-1:0];
    ien_n  = wdata[DATA_W-1 -: IEN_W] & IEN_MASK;
    lrst_n = hit_lctl & wdata[0];

    sts_n      = '0;
    sts_n[0]   = dma_active;
    sts_n[1]   = dma_err_set | (sts_q[1] & ~(hit_sts & wdata[1]));
    sts_n[2]   = dma_int_set | (sts_q[2] & ~(hit_sts & wdata[2]));
    sts_n[6:5] = hit_sts ? wdata[6:5] : sts_q[6:5];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      swd_q  <= '0;
      sts_q  <= '0;
      lctl_q <= '0;
      ien_q  <= '0;
      irq_q  <= 1'b0;
      lrst_q <= 1'b0;
    end else begin
      if (hit_cmd)  cmd_q  <= cmd_n;
      if (hit_swd)  swd_q  <= swd_n;
      if (hit_lctl) lctl_q <= lctl_n;
      if (hit_ien)  ien_q  <= ien_n;
      sts_q  <= sts_n;
      irq_q  <= irq_in;
      lrst_q <= lrst_n;
    end
  end

  always_comb begin
    view.cmd  = cmd_q;
    view.swd  = swd_q;
    view.sts  = sts_q;
    view.lctl = lctl_q;
    view.ien  = ien_q;
    view.irq  = irq_q;
  end

  assign link_rst = lrst_q;
endmodule

// File: rtl/dlc_rdmux.sv
module dlc_rdmux #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  dlc_pkg::chan_view_t [dlc_pkg::NCH-1:0] views,
  input  logic [dlc_pkg::NCH-1:0]             present,
  output logic [DATA_W-1:0]                   rdata
);
  import dlc_pkg::*;

  localparam logic [ADDR_W-1:0] A_SUM0 = ADDR_W'(ALIAS_BASE);
  localparam logic [ADDR_W-1:0] A_SUM1 = ADDR_W'(ALIAS_BASE + CH_STRIDE);

  logic [31:0] word;

  always_comb begin
    word = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(c * CH_STRIDE))
        word = {24'd0, views[c].cmd};
      if (addr == ADDR_W'(c * CH_STRIDE + 1))
        word = {26'd0, views[c].swd};
      if (addr == ADDR_W'(c * CH_STRIDE + 2))
        word = {24'd0, views[c].sts};
      if (addr == ADDR_W'(CFG_BASE + c * CFG_STRIDE)) begin
        word[31:16]   = CFG_HI;
        word[IRQ_BIT] = views[c].irq;
      end
      if (addr == ADDR_W'(LINK_BASE + c * LINK_STRIDE))
        word = {20'd0, views[c].lctl};
      if (addr == ADDR_W'(LINK_BASE + c * LINK_STRIDE + LSTS_OFF))
        word = present[c] ? {16'd0, LSTS_UP} : 32'd0;
      if (addr == ADDR_W'(LINK_BASE + c * LINK_STRIDE + IEN_OFF))
        word = {views[c].ien, 16'd0};
    end
    if (addr == A_SUM0) begin
      word[7:0]   = views[0].cmd;
      word[4]     = views[0].cmd[4] | views[0].irq;
      word[6]     = views[0].cmd[6] | views[1].irq;
      word[14]    = views[1].sts[2];
      word[23:16] = views[0].sts;
      word[31:24] = views[1].sts;
    end
    if (addr == A_SUM1) begin
      word[7:0]   = views[1].cmd;
      word[4]     = views[1].cmd[4] | views[1].irq;
      word[23:16] = views[1].sts;
    end
  end

  assign rdata = DATA_W'(word);
endmodule

// File: rtl/dual_link_csr.sv
module dual_link_csr #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        dev_irq,
  input  logic [1:0]        dev_present,
  input  logic [1:0]        dma_active,
  input  logic [1:0]        dma_err_set,
  input  logic [1:0]        dma_int_set,
  output logic              irq_out,
  output logic [1:0]        link_rst
);
  import dlc_pkg::*;

  chan_view_t [NCH-1:0] chan_views;
  logic       [NCH-1:0] irq_bits;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dlc_chan #(.CH(g), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chan_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (bus_addr),
      .wr          (bus_wr),
      .wdata       (bus_wdata),
      .irq_in      (dev_irq[g]),
      .dma_active  (dma_active[g]),
      .dma_err_set (dma_err_set[g]),
      .dma_int_set (dma_int_set[g]),
      .view        (chan_views[g]),
      .link_rst    (link_rst[g])
    );
    assign irq_bits[g] = chan_views[g].irq;
  end

  dlc_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rdmux_i (
    .addr    (bus_addr),
    .views   (chan_views),
    .present (dev_present),
    .rdata   (bus_rdata)
  );

  assign irq_out = |irq_bits;
endmodule

// File: rtl/dual_link_csr_chk.sv
module dual_link_csr_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic [ADDR_W-1:0]                    bus_addr,
  input logic                                 bus_wr,
  input logic [DATA_W-1:0]                    bus_wdata,
  input logic [DATA_W-1:0]                    bus_rdata,
  input logic [1:0]                           dev_irq,
  input logic [1:0]                           dma_int_set,
  input logic                                 irq_out,
  input logic [1:0]                           link_rst,
  input dlc_pkg::chan_view_t [dlc_pkg::NCH-1:0] chan_views
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq_out == (|$past(dev_irq)))); // R9

  AST_LRST0_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && link_rst[0]) |-> $past(bus_wr && bus_addr == ADDR_W'('h100) && bus_wdata[0])); // R6

  AST_LRST1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && link_rst[1]) |-> $past(bus_wr && bus_addr == ADDR_W'('h180) && bus_wdata[0])); // R6

  AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bus_wr && (bus_addr == ADDR_W'('h02) || bus_addr == ADDR_W'('h12))
                      && bus_wdata[2] && !dma_int_set[0])) |-> !chan_views[0].sts[2]); // R4

  AST_IEN_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h148) || bus_addr == ADDR_W'('h1C8)) |-> (bus_rdata[15:0] == '0)); // R7

  AST_CFG_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('hA0) || bus_addr == ADDR_W'('hE0)) |-> (bus_rdata[31:16] == 16'h6515)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h1FC) || bus_addr == ADDR_W'('h03)) |-> (bus_rdata == '0)); // R13
endmodule

bind dual_link_csr dual_link_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .dev_irq     (dev_irq),
  .dma_int_set (dma_int_set),
  .irq_out     (irq_out),
  .link_rst    (link_rst),
  .chan_views  (chan_views)
);

// File: tb/dual_link_csr_tb_top.sv
module dual_link_csr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  dev_irq = '0, dev_present = '0, dma_active = '0;
  logic [1:0]  dma_err_set = '0, dma_int_set = '0;
  logic        irq_out;
  logic [1:0]  link_rst;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_link_csr dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_irq(dev_irq),
    .dev_present(dev_present), .dma_active(dma_active),
    .dma_err_set(dma_err_set), .dma_int_set(dma_int_set),
    .irq_out(irq_out), .link_rst(link_rst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr_t(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_t(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_flags(input int c, input bit err, input bit intr);
    @(negedge clk);
    dma_err_set[c] = err; dma_int_set[c] = intr;
    @(negedge clk);
    dma_err_set = '0; dma_int_set = '0;
  endtask

  function automatic bit mapped_rd(input int a);
    return a == 'h00 || a == 'h01 || a == 'h02 || a == 'h08 || a == 'h09 || a == 'h0A ||
           a == 'h10 || a == 'h18 || a == 'hA0 || a == 'hE0 || a == 'h100 || a == 'h104 ||
           a == 'h148 || a == 'h180 || a == 'h184 || a == 'h1C8;
  endfunction

  function automatic bit mapped_wr(input int a);
    return a == 'h00 || a == 'h01 || a == 'h02 || a == 'h08 || a == 'h09 || a == 'h0A ||
           a == 'h10 || a == 'h11 || a == 'h12 || a == 'h18 || a == 'h19 || a == 'h1A ||
           a == 'h100 || a == 'h148 || a == 'h180 || a == 'h1C8;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] snap [0:15];
    int snap_a [0:15];
    int k;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_t(9'hA0, r);  chk("R1 cfg0", r, 32'h6515_0000);
    rd_t(9'hE0, r);  chk("R1 cfg1", r, 32'h6515_0000);
    rd_t(9'h00, r);  chk("R1 cmd0", r, 0);
    rd_t(9'h0A, r);  chk("R1 sts1", r, 0);
    rd_t(9'h148, r); chk("R1 ien0", r, 0);
    chk("R1 irq_out", {31'd0, irq_out}, 0);
    chk("R1 link_rst", {30'd0, link_rst}, 0);

    // R2 / R3 full byte sweeps, direct and alias offsets
    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < 256; v++) begin
        wr_t(9'((v % 2 ? 'h10 : 0) + c * 8), v);
        rd_t(9'(c * 8), r);     chk("R2 cmd", r, v);
        wr_t(9'((v % 2 ? 'h11 : 1) + c * 8), 32'hFFFF_FF00 | v);
        rd_t(9'(c * 8 + 1), r); chk("R3 swd", r, v & 'h3F);
      end
    end

    // R4 status write rules after both flags were set
    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < 256; v++) begin
        pulse_flags(c, 1'b1, 1'b1);
        wr_t(9'((v % 2 ? 'h12 : 2) + c * 8), v);
        rd_t(9'(c * 8 + 2), r);
        chk("R4 sts", r, (v & 'h60) | (~v & 'h06));
      end
    end

    // R5 set beats a clearing write in the same cycle
    @(negedge clk);
    bus_addr = 9'h02; bus_wdata = 32'h04; bus_wr = 1'b1; dma_int_set[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; dma_int_set = '0;
    rd_t(9'h02, r); chk("R5 set wins", r, 32'h04);
    // R5 active level tracking, bit 0 untouched by writes
    @(negedge clk); dma_active[1] = 1'b1;
    rd_t(9'h0A, r); chk("R5 active on", r & 32'h1, 1);
    wr_t(9'h0A, 32'h01);
    rd_t(9'h0A, r); chk("R5 active held", r & 32'h1, 1);
    @(negedge clk); dma_active[1] = 1'b0;
    rd_t(9'h0A, r); chk("R5 active off", r & 32'h1, 0);

    // R6 link control field and reset pulse
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      bus_addr = 9'('h100 + c * 'h80); bus_wdata = 32'hABCD_E5A5; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R6 pulse high", {30'd0, link_rst}, 32'(1 << c));
      @(negedge clk);
      chk("R6 pulse width", {30'd0, link_rst}, 0);
      rd_t(9'('h100 + c * 'h80), r); chk("R6 lctl", r, 32'h5A5);
      @(negedge clk);
      bus_addr = 9'('h100 + c * 'h80); bus_wdata = 32'h0000_0FFE; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R6 no pulse", {30'd0, link_rst}, 0);
      rd_t(9'('h100 + c * 'h80), r); chk("R6 lctl2", r, 32'hFFE);
    end

    // R7 interrupt-enable mask, one bit at a time
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 16; b++) begin
        wr_t(9'('h148 + c * 'h80), (32'h1 << (b + 16)) | 32'hFFFF);
        rd_t(9'('h148 + c * 'h80), r);
        chk("R7 ien", r, ((32'h1 << b) & 32'h3EED) << 16);
      end
      wr_t(9'('h148 + c * 'h80), 32'hFFFF_FFFF);
      rd_t(9'('h148 + c * 'h80), r); chk("R7 ien all", r, 32'h3EED_0000);
    end

    // R8 / R9 interrupt levels
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); dev_irq = 2'(m);
      rd_t(9'hA0, r); chk("R8 cfg0", r, 32'h6515_0000 | ((m & 1) << 11));
      rd_t(9'hE0, r); chk("R8 cfg1", r, 32'h6515_0000 | (((m >> 1) & 1) << 11));
      chk("R9 irq_out", {31'd0, irq_out}, (m != 0) ? 1 : 0);
    end

    // R10 / R11 summary words
    wr_t(9'h00, 32'h81);
    wr_t(9'h08, 32'h01);
    pulse_flags(0, 1'b1, 1'b1);
    wr_t(9'h02, 32'h20);
    pulse_flags(1, 1'b0, 1'b1);
    wr_t(9'h0A, 32'h40);
    @(negedge clk); dev_irq = 2'b11;
    rd_t(9'h10, r); chk("R10 sum0 irq", r, 32'h4426_40D1);
    rd_t(9'h18, r); chk("R11 sum1 irq", r, 32'h0044_0011);
    wr_t(9'h0A, 32'h04);
    @(negedge clk); dev_irq = 2'b00;
    rd_t(9'h10, r); chk("R10 sum0 quiet", r, 32'h0026_0081);
    rd_t(9'h18, r); chk("R11 sum1 quiet", r, 32'h0000_0001);

    // R12 link status
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); dev_present = 2'(m);
      rd_t(9'h104, r); chk("R12 lsts0", r, (m & 1) ? 32'h113 : 0);
      rd_t(9'h184, r); chk("R12 lsts1", r, (m & 2) ? 32'h113 : 0);
    end
    @(negedge clk); dev_present = '0;

    // R13 snapshot, write sweep over unmapped/read-only, read sweep
    k = 0;
    for (int a = 0; a < 512; a++) begin
      if (mapped_rd(a)) begin
        snap_a[k] = a;
        rd_t(9'(a), snap[k]);
        k++;
      end
    end
    for (int a = 0; a < 512; a++)
      if (!mapped_wr(a)) wr_t(9'(a), 32'hFFFF_FFFF);
    chk("R13 no pulse", {30'd0, link_rst}, 0);
    for (int i = 0; i < 16; i++) begin
      rd_t(9'(snap_a[i]), r); chk("R13 unchanged", r, snap[i]);
    end
    for (int a = 0; a < 512; a++) begin
      if (!mapped_rd(a)) begin
        rd_t(9'(a), r); chk("R13 unmapped", r, 0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule